// File: doc/BRIEF.md
# Tick-Driven Interval Timer Bank

A bank of identical down-counting interval timers. They share a microsecond timebase that arrives as a one-cycle enable pulse (`tick_en`), and they share one simple register bus. Each timer counts down on every timebase pulse while it is armed. When a pulse arrives with the count already at zero, the timer flags an expiry. That flag drives an active-high level interrupt line, which stays asserted until software clears it.

Software programs a timer through its control word. That word holds an arm bit, an auto-reload bit and a 29-bit count. With auto-reload off, the timer disarms itself after one expiry. With auto-reload on, it refills its count from the programmed value and keeps running, which gives a fixed-rate periodic interrupt.

A second word per timer reports the live count and the pending flag. Writing the pending bit of that word acknowledges the interrupt. The timers sit at fixed, non-contiguous bus addresses, so system software can reach them at known locations.

Top module: `tick_timer_bank`

## Requirements
- R1: After a synchronous reset every timer is disarmed with zero count, zero reload value and no pending flag, all `irq` bits are 0, and every register reads as 0.
- R2: A write to a control word (timer offset +0) sets arm from bit 31, auto-reload from bit 30, and both the reload value and the live count from bits 28:0 (maximum 0x1FFFFFFF). Bit 29 is ignored. Reading the control word returns arm in bit 31, auto-reload in bit 30, the reload value in bits 28:0, and 0 elsewhere.
- R3: An armed timer loaded with value v raises its pending flag on the (v+1)-th timebase pulse after the load (v = 0 expires on the first pulse). The count decrements by one per pulse and holds in cycles without a pulse.
- R4: The pending flag drives `irq[i]` directly, as an active-high level. It stays set until a write to the status word (timer offset +4) with bit 30 = 1. A status write with bit 30 = 0 has no effect. Reading the status word returns the pending flag in bit 30, the live count in bits 28:0, and 0 elsewhere.
- R5: In one-shot mode (bit 30 = 0), expiry clears the arm bit. The count stays at 0 and no further expiry occurs.
- R6: In auto-reload mode (bit 30 = 1), expiry copies the reload value into the count and the timer stays armed, so it expires again every v+1 pulses.
- R7: A control word write restarts the timer from the new value even while it is running, and the pending flag is left unchanged. Writing a word with bit 31 = 0, such as zero, stops the timer.
- R8: If a status-word clear and an expiry of the same timer fall in the same cycle, the pending flag ends up set.
- R9: Timer i sits at base 0x00, 0x08, 0x50 or 0x58 for i = 0 to 3. Writes to any other address change nothing, and reads of any other address return 0.
- R10: Read data appears on `bus_rdata` one clock after the cycle in which `bus_re` is high, and reflects the register state before that cycle's updates.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | One-cycle timebase pulse (one per microsecond) |
| bus_addr | input | 8 | Byte address of the register accessed |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_re | input | 1 | Read strobe |
| bus_rdata | output | 32 | Registered read data |
| irq | output | 4 | Per-timer level interrupt, active high |

## Verification
The assertions assume `tick_en` and the bus strobes are synchronous to `clk`. They also assume that a single bus access targets at most one register per cycle, so a control-word load and a status clear never reach the same timer together. The stimulus keeps to this by issuing at most one access per cycle, with addresses drawn from the eight mapped words plus a few unmapped ones. Counts are biased toward small values so that expiries, reloads and clear/expiry collisions happen often, and a few maximum-value loads check the field width.

// File: rtl/tick_timer_pkg.sv
`timescale 1ns/1ps
package tick_timer_pkg;
  localparam int REG_W      = 32;
  localparam int CNT_W      = 29;
  localparam int ARM_BIT    = 31;
  localparam int RELOAD_BIT = 30;
  localparam int PEND_BIT   = 30;
  localparam int STATUS_OFS = 4;
  localparam int PAIR_STEP  = 'h50;
  localparam int SLOT_STEP  = 'h08;

  typedef struct packed {
    logic             arm;
    logic             autoreload;
    logic [CNT_W-1:0] reload;
  } tmr_ctrl_t;

  // Timers come in pairs: pair k at k*0x50, second of pair at +0x08.
  function automatic int timer_base(input int idx);
    return (idx / 2) * PAIR_STEP + (idx % 2) * SLOT_STEP;
  endfunction
endpackage

// File: rtl/tick_timer_decode.sv
`timescale 1ns/1ps
module tick_timer_decode
  import tick_timer_pkg::*;
#(
  parameter int NUM_TIMERS = 4,
  parameter int ADDR_W     = 8,
  parameter int IDX_W      = 2
) (
  input  logic [ADDR_W-1:0]     addr,
  input  logic                  we,
  output logic [NUM_TIMERS-1:0] load_we,
  output logic [NUM_TIMERS-1:0] clr_we,
  output logic                  hit,
  output logic [IDX_W-1:0]      idx,
  output logic                  is_status
);
  genvar g;
  generate
    for (g = 0; g < NUM_TIMERS; g++) begin : g_strobe
      localparam logic [ADDR_W-1:0] CtrlA = ADDR_W'(timer_base(g));
      localparam logic [ADDR_W-1:0] StatA = ADDR_W'(timer_base(g) + STATUS_OFS);
      assign load_we[g] = we && (addr == CtrlA);
      assign clr_we[g]  = we && (addr == StatA);
    end
  endgenerate

  always_comb begin
    hit       = 1'b0;
    idx       = '0;
    is_status = 1'b0;
    for (int i = 0; i < NUM_TIMERS; i++) begin
      if (addr == ADDR_W'(timer_base(i))) begin
        hit = 1'b1;
        idx = IDX_W'(i);
      end else if (addr == ADDR_W'(timer_base(i) + STATUS_OFS)) begin
        hit       = 1'b1;
        idx       = IDX_W'(i);
        is_status = 1'b1;
      end
    end
  end
endmodule

// File: rtl/tick_timer_core.sv
`timescale 1ns/1ps
module tick_timer_core
  import tick_timer_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             load_we,
  input  logic             load_arm,
  input  logic             load_auto,
  input  logic [CNT_W-1:0] load_val,
  input  logic             clr_we,
  input  logic             clr_bit,
  output tmr_ctrl_t        ctrl_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic             pend_o
);
  tmr_ctrl_t        ctrl_q;
  logic [CNT_W-1:0] cnt_q;
  logic             pend_q;
  logic             at_zero;
  logic             expire;
  logic             clr_req;

  assign at_zero = (cnt_q == '0);
  assign expire  = ctrl_q.arm & tick & at_zero & ~load_we;
  assign clr_req = clr_we & clr_bit;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
      cnt_q  <= '0;
    end else if (load_we) begin
      ctrl_q.arm        <= load_arm;
      ctrl_q.autoreload <= load_auto;
      ctrl_q.reload     <= load_val;
      cnt_q             <= load_val;
    end else if (ctrl_q.arm && tick) begin
      if (at_zero) begin
        if (ctrl_q.autoreload) cnt_q <= ctrl_q.reload;
        else                   ctrl_q.arm <= 1'b0;
      end else begin
        cnt_q <= cnt_q - 1'b1;
      end
    end
  end

  // Expiry has priority over a clear in the same cycle.
  always_ff @(posedge clk) begin
    if (rst)          pend_q <= 1'b0;
    else if (expire)  pend_q <= 1'b1;
    else if (clr_req) pend_q <= 1'b0;
  end

  assign ctrl_o = ctrl_q;
  assign cnt_o  = cnt_q;
  assign pend_o = pend_q;

  // R5
  oneshot_stop_chk: assert property (@(posedge clk) disable iff (rst)
    (ctrl_q.arm && !ctrl_q.autoreload && tick && at_zero && !load_we) |=> !ctrl_q.arm);
  // R6
  autoreload_refill_chk: assert property (@(posedge clk) disable iff (rst)
    (ctrl_q.arm && ctrl_q.autoreload && tick && at_zero && !load_we)
      |=> (ctrl_q.arm && cnt_q == $past(ctrl_q.reload)));
  // R8
  expiry_beats_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (ctrl_q.arm && tick && at_zero && !load_we && clr_we && clr_bit) |=> pend_q);
  // R4
  pend_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (pend_q && !(clr_we && clr_bit)) |=> pend_q);
  // R3
  count_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!tick && !load_we) |=> $stable(cnt_q));
  // R3
  count_step_chk: assert property (@(posedge clk) disable iff (rst)
    (ctrl_q.arm && tick && !at_zero && !load_we) |=> (cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/tick_timer_readmux.sv
`timescale 1ns/1ps
module tick_timer_readmux
  import tick_timer_pkg::*;
#(
  parameter int NUM_TIMERS = 4,
  parameter int IDX_W      = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             re,
  input  logic             hit,
  input  logic [IDX_W-1:0] idx,
  input  logic             is_status,
  input  tmr_ctrl_t        ctrl_i [NUM_TIMERS],
  input  logic [CNT_W-1:0] cnt_i  [NUM_TIMERS],
  input  logic             pend_i [NUM_TIMERS],
  output logic [REG_W-1:0] rdata
);
  logic [REG_W-1:0] word;

  always_comb begin
    word = '0;
    if (hit) begin
      if (is_status) begin
        word[PEND_BIT]    = pend_i[idx];
        word[CNT_W-1:0]   = cnt_i[idx];
      end else begin
        word[ARM_BIT]     = ctrl_i[idx].arm;
        word[RELOAD_BIT]  = ctrl_i[idx].autoreload;
        word[CNT_W-1:0]   = ctrl_i[idx].reload;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)     rdata <= '0;
    else if (re) rdata <= word;
  end

  // R9
  miss_reads_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (re && !hit) |=> (rdata == '0));
endmodule

// File: rtl/tick_timer_bank.sv
`timescale 1ns/1ps
module tick_timer_bank
  import tick_timer_pkg::*;
#(
  parameter int NUM_TIMERS = 4,
  parameter int ADDR_W     = 8
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  tick_en,
  input  logic [ADDR_W-1:0]     bus_addr,
  input  logic                  bus_we,
  input  logic [REG_W-1:0]      bus_wdata,
  input  logic                  bus_re,
  output logic [REG_W-1:0]      bus_rdata,
  output logic [NUM_TIMERS-1:0] irq
);
  localparam int IDX_W = (NUM_TIMERS > 1) ? $clog2(NUM_TIMERS) : 1;

  logic [NUM_TIMERS-1:0] load_we;
  logic [NUM_TIMERS-1:0] clr_we;
  logic                  hit;
  logic [IDX_W-1:0]      idx;
  logic                  is_status;
  tmr_ctrl_t             ctrl_v [NUM_TIMERS];
  logic [CNT_W-1:0]      cnt_v  [NUM_TIMERS];
  logic                  pend_v [NUM_TIMERS];
  logic                  unused_bit29;

  assign unused_bit29 = bus_wdata[29];

  tick_timer_decode #(
    .NUM_TIMERS(NUM_TIMERS), .ADDR_W(ADDR_W), .IDX_W(IDX_W)
  ) decode_i (
    .addr(bus_addr), .we(bus_we), .load_we(load_we), .clr_we(clr_we),
    .hit(hit), .idx(idx), .is_status(is_status)
  );

  genvar g;
  generate
    for (g = 0; g < NUM_TIMERS; g++) begin : g_tmr
      tick_timer_core core_i (
        .clk(clk), .rst(rst), .tick(tick_en),
        .load_we(load_we[g]),
        .load_arm(bus_wdata[ARM_BIT]),
        .load_auto(bus_wdata[RELOAD_BIT]),
        .load_val(bus_wdata[CNT_W-1:0]),
        .clr_we(clr_we[g]),
        .clr_bit(bus_wdata[PEND_BIT]),
        .ctrl_o(ctrl_v[g]), .cnt_o(cnt_v[g]), .pend_o(pend_v[g])
      );
      assign irq[g] = pend_v[g];
    end
  endgenerate

  tick_timer_readmux #(
    .NUM_TIMERS(NUM_TIMERS), .IDX_W(IDX_W)
  ) readmux_i (
    .clk(clk), .rst(rst), .re(bus_re), .hit(hit), .idx(idx),
    .is_status(is_status), .ctrl_i(ctrl_v), .cnt_i(cnt_v),
    .pend_i(pend_v), .rdata(bus_rdata)
  );
endmodule

// File: tb/tick_timer_bank_tb_top.sv
`timescale 1ns/1ps
module tick_timer_bank_tb_top;
  localparam int N = 4;

  logic        clk = 1'b0;
  logic        rst, tick_en, bus_we, bus_re;
  logic [7:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic [N-1:0] irq;

  always #2 clk = ~clk;

  tick_timer_bank dut_i (
    .clk(clk), .rst(rst), .tick_en(tick_en), .bus_addr(bus_addr),
    .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_re(bus_re),
    .bus_rdata(bus_rdata), .irq(irq)
  );

  int checks = 0, fails = 0;
  bit done = 0;
  bit        m_arm [N];
  bit        m_auto[N];
  bit [28:0] m_rel [N];
  bit [28:0] m_cnt [N];
  bit        m_pend[N];

  function automatic int base_of(int i);
    return (i / 2) * 'h50 + (i % 2) * 8;
  endfunction

  // R9/R2/R4: expected read word from the model state
  function automatic bit [31:0] exp_read(bit [7:0] a);
    bit [31:0] w = 0;
    for (int i = 0; i < N; i++) begin
      if (a == 8'(base_of(i)))
        w = {m_arm[i], m_auto[i], 1'b0, m_rel[i]};
      else if (a == 8'(base_of(i) + 4))
        w = {1'b0, m_pend[i], 1'b0, m_cnt[i]};
    end
    return w;
  endfunction

  function automatic bit [N-1:0] exp_irq();
    bit [N-1:0] v;
    for (int i = 0; i < N; i++) v[i] = m_pend[i];
    return v;
  endfunction

  task automatic check(string req, bit [31:0] act, bit [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < N; i++) begin
      m_arm[i] = 0; m_auto[i] = 0; m_rel[i] = 0; m_cnt[i] = 0; m_pend[i] = 0;
    end
  endtask

  task automatic model_step(bit we, bit [7:0] a, bit [31:0] d, bit tk);
    for (int i = 0; i < N; i++) begin
      bit ld  = we && (a == 8'(base_of(i)));
      bit cl  = we && (a == 8'(base_of(i) + 4)) && d[30];
      bit exq = m_arm[i] && tk && (m_cnt[i] == 0) && !ld;
      if (ld) begin
        m_arm[i] = d[31]; m_auto[i] = d[30]; m_rel[i] = d[28:0]; m_cnt[i] = d[28:0];
      end else if (m_arm[i] && tk) begin
        if (m_cnt[i] == 0) begin
          if (m_auto[i]) m_cnt[i] = m_rel[i];
          else           m_arm[i] = 0;
        end else m_cnt[i] = m_cnt[i] - 1;
      end
      if (exq) m_pend[i] = 1;
      else if (cl) m_pend[i] = 0;
    end
  endtask

  // One bus cycle; R10: read data checked one clock after the strobe.
  task automatic cyc(string req, bit we, bit re, bit [7:0] a, bit [31:0] d, bit tk);
    bit [31:0] er;
    @(negedge clk);
    bus_we = we; bus_re = re; bus_addr = a; bus_wdata = d; tick_en = tk;
    er = exp_read(a);
    @(posedge clk);
    model_step(we, a, d, tk);
    #1;
    if (re) check({req, "/R10 read"}, bus_rdata, er);
    check({req, " irq"}, 32'(irq), 32'(exp_irq()));
  endtask

  task automatic wr(string req, bit [7:0] a, bit [31:0] d, bit tk = 0);
    cyc(req, 1, 0, a, d, tk);
  endtask
  task automatic rd(string req, bit [7:0] a);
    cyc(req, 0, 1, a, 0, 0);
  endtask
  task automatic ticks(string req, int n);
    for (int k = 0; k < n; k++) cyc(req, 0, 0, 0, 0, 1);
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    rst = 1; tick_en = 0; bus_we = 0; bus_re = 0; bus_addr = 0; bus_wdata = 0;
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;

    // R1: reset state
    for (int i = 0; i < N; i++) begin
      rd("R1", 8'(base_of(i)));
      rd("R1", 8'(base_of(i) + 4));
    end

    // R2: field layout, bit 29 ignored, maximum count
    wr("R2", 8'h08, 32'hA000_0005);
    rd("R2", 8'h08);
    check("R2 ctrl readback", bus_rdata, 32'h8000_0005);
    wr("R2", 8'h08, 32'h9FFF_FFFF);
    rd("R2", 8'h08);
    check("R2 max", bus_rdata, 32'h9FFF_FFFF);
    rd("R2", 8'h0C);
    wr("R7 stop", 8'h08, 32'h0);
    ticks("R7 stop", 3);
    rd("R7 stop", 8'h0C);

    // R3/R5: value 3 expires on 4th tick, one-shot disarms
    wr("R3", 8'h00, 32'h8000_0003);
    ticks("R3", 3);
    check("R3 before expiry", 32'(irq[0]), 0);
    cyc("R3 hold", 0, 0, 0, 0, 0);
    ticks("R3", 1);
    check("R3 expiry", 32'(irq[0]), 1);
    ticks("R5", 4);
    rd("R5", 8'h00);
    check("R5 disarmed", bus_rdata, 32'h0000_0003);
    rd("R5", 8'h04);
    // R4: clear with bit30=0 ignored, then real clear
    wr("R4 no-op", 8'h04, 32'hBFFF_FFFF);
    check("R4 no-op", 32'(irq[0]), 1);
    wr("R4 clear", 8'h04, 32'h4000_0000);
    check("R4 cleared", 32'(irq[0]), 0);

    // R3: value 0 expires on the first tick
    wr("R3 zero", 8'h08, 32'h8000_0000);
    ticks("R3 zero", 1);
    check("R3 zero", 32'(irq[1]), 1);
    wr("R4", 8'h0C, 32'h4000_0000);

    // R6: auto-reload value 1 -> every 2 ticks
    wr("R6", 8'h50, 32'hC000_0001);
    for (int r = 0; r < 3; r++) begin
      ticks("R6", 2);
      check("R6 periodic", 32'(irq[2]), 1);
      rd("R6", 8'h54);
      check("R6 reloaded", bus_rdata, 32'h4000_0001);
      wr("R6", 8'h54, 32'h4000_0000);
    end
    wr("R7", 8'h50, 32'h0);

    // R8: clear and expiry in the same cycle
    wr("R8", 8'h58, 32'h8000_0000);
    wr("R8", 8'h5C, 32'h4000_0000, 1);
    check("R8 expiry wins", 32'(irq[3]), 1);
    wr("R4", 8'h5C, 32'h4000_0000);

    // R7: restart while running, pending kept
    wr("R7", 8'h58, 32'h8000_0000);
    ticks("R7", 1);
    wr("R7", 8'h58, 32'h8000_0005);
    ticks("R7", 2);
    rd("R7", 8'h5C);
    check("R7 restart", bus_rdata, 32'h4000_0003);
    wr("R7", 8'h58, 32'h8000_0009, 1);
    rd("R7", 8'h5C);
    check("R7 load over tick", bus_rdata, 32'h4000_0009);
    wr("R7", 8'h58, 32'h0);

    // R9: unmapped writes/reads
    wr("R9", 8'h10, 32'hFFFF_FFFF);
    wr("R9", 8'h4C, 32'hFFFF_FFFF);
    wr("R9", 8'h60, 32'hFFFF_FFFF);
    rd("R9", 8'h10);
    rd("R9", 8'h60);
    for (int i = 0; i < N; i++) rd("R9", 8'(base_of(i)));

    // Random mix
    for (int k = 0; k < 4000; k++) begin
      int sel = $urandom_range(0, 9);
      bit [7:0] a;
      bit [31:0] d = $urandom;
      bit tk = $urandom_range(0, 1);
      if (sel < 8) a = 8'(base_of(sel / 2) + (sel % 2) * 4);
      else a = 8'($urandom_range(0, 255));
      if ($urandom_range(0, 9) != 0) d[28:0] = 29'($urandom_range(0, 6));
      case ($urandom_range(0, 3))
        0:       cyc("R3 rand", 1, 0, a, d, tk);
        1:       cyc("R9 rand", 0, 1, a, 0, tk);
        default: cyc("R6 rand", 0, 0, 0, 0, tk);
      endcase
    end

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule